// File: doc/BRIEF.md
# Address-Region Endian Word Swapper

This block sits in the data path of a bus bridge between a processor and memory-mapped register space. It holds a bank of programmable address windows. Each window has a base address, a four-bit size code and a disable flag. When an enabled window contains a write request's address, the block exchanges the two 32-bit words of the 64-bit write data and the matching halves of the byte strobes. Read responses get the same treatment, keyed on the address that the bridge returns with each response beat. Traffic outside every enabled window goes through unchanged.

Swapping is a pure combinational path, so a request or response leaves the block in the cycle it enters, whether or not it is swapped. Valid and ready pass straight through. A small register port selects a window and one of its three registers (base, size, disable). Writes to that port take effect at the next clock edge. Reads from it are combinational.

Top module: `endian_region_swapper`

## Requirements
- R1: After reset the size codes of windows 0 to 7 read 6, 9, 4, 8, 5, 10, 0 and 0. Every disable flag reads 0 and every base reads 0.
- R2: The size register (cfg_sel = 1) keeps only write data bits 3:0. Bits 31:4 always read as zero, whatever value was written.
- R3: The base register (cfg_sel = 0) keeps write data bits 31:16, which are address bits 31:16 of a 64 KB aligned base. Bits 15:0 always read as zero.
- R4: The disable register (cfg_sel = 2) keeps write data bit 0. Bits 31:1 always read as zero.
- R5: A window with size code n (0 to 11) covers the 64 KB × 2^n bytes that start at its base. Its first and last byte match. The byte just past its end and the byte just below its base do not match.
- R6: A window whose size code is 12 to 15 never matches any address.
- R7: A window whose disable flag is 1 never matches any address.
- R8: A write request that matches leaves with data bits 63:32 and 31:0 exchanged, and with strobe bits 7:4 and 3:0 exchanged. This happens in the same cycle.
- R9: A read response whose returned address matches leaves with data bits 63:32 and 31:0 exchanged. This happens in the same cycle.
- R10: Requests and responses that match no window pass through unchanged in the same cycle. The valid, ready and address signals always pass through unchanged.
- R11: An address that falls inside several enabled windows is swapped exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_region | input | 3 | Window index |
| cfg_sel | input | 2 | Register select: 0 base, 1 size, 2 disable |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Upstream request ready |
| req_addr | input | 32 | Request address |
| req_wdata | input | 64 | Request write data |
| req_wstrb | input | 8 | Request byte strobes |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request ready |
| dn_addr | output | 32 | Downstream request address |
| dn_wdata | output | 64 | Downstream write data, possibly swapped |
| dn_wstrb | output | 8 | Downstream strobes, possibly swapped |
| dn_rsp_valid | input | 1 | Downstream read response valid |
| dn_rsp_ready | output | 1 | Downstream read response ready |
| dn_rsp_addr | input | 32 | Address of the returning read beat |
| dn_rsp_rdata | input | 64 | Read data from downstream |
| up_rsp_valid | output | 1 | Upstream read response valid |
| up_rsp_ready | input | 1 | Upstream read response ready |
| up_rsp_rdata | output | 64 | Read data to upstream, possibly swapped |

## Verification
The only state in the block is the window configuration, and every bit of it can be read back on the register port in the cycle after it is written. A corrupted base, size or disable flag therefore shows up on the next read of that window. It also shows up in the same cycle on the data outputs as a swap that is missing or unwanted, but only for addresses close to that window's edges. For this reason the stimulus aims many addresses at window bases, at the last byte inside a window, and at the bytes just outside it. Because the path has no latency, a decode fault cannot hide behind a pipeline. Every mismatch is seen on the beat that caused it.

// File: rtl/region_swap_pkg.sv
// Shared constants, types and reset defaults for the endian region swapper.
// Assumes a 64 KB granule: base registers hold address bits above BASE_LSB.
package region_swap_pkg;

    localparam int BASE_LSB      = 16;  // 64 KB granule
    localparam int SIZE_W        = 4;   // width of the size code
    localparam int MAX_SIZE_CODE = 11;  // largest legal code (128 MB)

    // Register select on the configuration port.
    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_SIZE = 2'd1,
        SEL_DIS  = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    // Reset size code of a given window.
    function automatic logic [SIZE_W-1:0] default_size(input int idx);
        case (idx)
            0:       return SIZE_W'(6);
            1:       return SIZE_W'(9);
            2:       return SIZE_W'(4);
            3:       return SIZE_W'(8);
            4:       return SIZE_W'(5);
            5:       return SIZE_W'(10);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/region_cfg_regs.sv
// Per-window configuration storage: base, size code and disable flag.
// Assumes a single write port and a combinational read port. Unused bits
// read as zero and are never stored.
module region_cfg_regs
    import region_swap_pkg::*;
#(
    parameter  int NUM_REGIONS = 8,
    parameter  int ADDR_W      = 32,
    localparam int IDX_W       = $clog2(NUM_REGIONS),
    localparam int BASE_W      = ADDR_W - BASE_LSB
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_region,
    input  cfg_sel_e              cfg_sel,
    input  logic [ADDR_W-1:0]     cfg_wdata,
    output logic [ADDR_W-1:0]     cfg_rdata,
    output logic [BASE_W-1:0]     base_q [NUM_REGIONS],
    output logic [SIZE_W-1:0]     size_q [NUM_REGIONS],
    output logic [NUM_REGIONS-1:0] dis_q
);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        logic [BASE_W-1:0] base_r;
        logic [SIZE_W-1:0] size_r;
        logic              dis_r;
        logic              hit_wr;

        assign hit_wr = cfg_we && (cfg_region == IDX_W'(g));

        // Update one window's registers on a write addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_r <= '0;
                size_r <= default_size(g);
                dis_r  <= 1'b0;
            end else if (hit_wr) begin
                case (cfg_sel)
                    SEL_BASE: base_r <= cfg_wdata[ADDR_W-1:BASE_LSB];
                    SEL_SIZE: size_r <= cfg_wdata[SIZE_W-1:0];
                    SEL_DIS:  dis_r  <= cfg_wdata[0];
                    default:  ;
                endcase
            end
        end

        assign base_q[g] = base_r;
        assign size_q[g] = size_r;
        assign dis_q[g]  = dis_r;
    end

    // Return the selected register, with unused bits forced to zero.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_BASE: cfg_rdata[ADDR_W-1:BASE_LSB] = base_q[cfg_region];
            SEL_SIZE: cfg_rdata[SIZE_W-1:0]        = size_q[cfg_region];
            SEL_DIS:  cfg_rdata[0]                 = dis_q[cfg_region];
            default:  cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/region_match.sv
// Address decoder: reports whether an address lies inside any enabled
// window with a legal size code. Overlapping windows are OR-reduced, so a
// hit is a single flag no matter how many windows contain the address.
module region_match
    import region_swap_pkg::*;
#(
    parameter  int NUM_REGIONS = 8,
    parameter  int ADDR_W      = 32,
    localparam int BASE_W      = ADDR_W - BASE_LSB
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [BASE_W-1:0]      base_q [NUM_REGIONS],
    input  logic [SIZE_W-1:0]      size_q [NUM_REGIONS],
    input  logic [NUM_REGIONS-1:0] dis_q,
    output logic                   hit
);

    logic [NUM_REGIONS-1:0] region_hit;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        logic [BASE_W-1:0] keep;
        logic              legal;

        // Build the mask of granule bits that must equal the base.
        always_comb begin
            for (int b = 0; b < BASE_W; b++) begin
                keep[b] = (b >= int'(size_q[g]));
            end
        end

        assign legal = (size_q[g] <= SIZE_W'(MAX_SIZE_CODE));
        assign region_hit[g] = !dis_q[g] && legal &&
            (((addr[ADDR_W-1:BASE_LSB] ^ base_q[g]) & keep) == '0);
    end

    assign hit = |region_hit;

endmodule

// File: rtl/word_swap.sv
// Conditional exchange of the upper and lower halves of a vector.
// Assumes an even width.
module word_swap #(
    parameter int W = 64
) (
    input  logic         swap,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    assign dout = swap ? {din[W/2-1:0], din[W-1:W/2]} : din;

endmodule

// File: rtl/endian_region_swapper.sv
// Top: selective word swapper for a 64-bit bridge data path. Write requests
// are decoded on req_addr and read responses on dn_rsp_addr. Both paths are
// combinational, so swapped and unswapped beats have the same zero latency.
// Handshakes pass through untouched.
module endian_region_swapper
    import region_swap_pkg::*;
#(
    parameter  int NUM_REGIONS = 8,
    parameter  int ADDR_W      = 32,
    parameter  int DATA_W      = 64,
    localparam int IDX_W       = $clog2(NUM_REGIONS),
    localparam int STRB_W      = DATA_W / 8,
    localparam int BASE_W      = ADDR_W - BASE_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_region,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [STRB_W-1:0] req_wstrb,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    output logic [STRB_W-1:0] dn_wstrb,
    input  logic              dn_rsp_valid,
    output logic              dn_rsp_ready,
    input  logic [ADDR_W-1:0] dn_rsp_addr,
    input  logic [DATA_W-1:0] dn_rsp_rdata,
    output logic              up_rsp_valid,
    input  logic              up_rsp_ready,
    output logic [DATA_W-1:0] up_rsp_rdata
);

    logic [BASE_W-1:0]      base_q [NUM_REGIONS];
    logic [SIZE_W-1:0]      size_q [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] dis_q;
    logic                   req_hit;
    logic                   rsp_hit;

    region_cfg_regs #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_region (cfg_region),
        .cfg_sel    (cfg_sel_e'(cfg_sel)),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .base_q     (base_q),
        .size_q     (size_q),
        .dis_q      (dis_q)
    );

    region_match #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_req_match (
        .addr   (req_addr),
        .base_q (base_q),
        .size_q (size_q),
        .dis_q  (dis_q),
        .hit    (req_hit)
    );

    region_match #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_rsp_match (
        .addr   (dn_rsp_addr),
        .base_q (base_q),
        .size_q (size_q),
        .dis_q  (dis_q),
        .hit    (rsp_hit)
    );

    word_swap #(.W(DATA_W)) u_wdata_swap (
        .swap (req_hit), .din (req_wdata), .dout (dn_wdata)
    );

    word_swap #(.W(STRB_W)) u_wstrb_swap (
        .swap (req_hit), .din (req_wstrb), .dout (dn_wstrb)
    );

    word_swap #(.W(DATA_W)) u_rdata_swap (
        .swap (rsp_hit), .din (dn_rsp_rdata), .dout (up_rsp_rdata)
    );

    // Handshake and address pass-through.
    assign dn_valid     = req_valid;
    assign req_ready    = dn_ready;
    assign dn_addr      = req_addr;
    assign up_rsp_valid = dn_rsp_valid;
    assign dn_rsp_ready = up_rsp_ready;

endmodule

// File: rtl/region_swap_checker.sv
// Assertion checker for endian_region_swapper. It relates the decoder flags
// to the data ports and checks the register read-back format.
module region_swap_checker #(
    parameter  int ADDR_W = 32,
    parameter  int DATA_W = 64,
    localparam int STRB_W = DATA_W / 8,
    localparam int HD     = DATA_W / 2,
    localparam int HS     = STRB_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_sel,
    input logic [ADDR_W-1:0] cfg_rdata,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic [STRB_W-1:0] req_wstrb,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic [ADDR_W-1:0] dn_addr,
    input logic [DATA_W-1:0] dn_wdata,
    input logic [STRB_W-1:0] dn_wstrb,
    input logic [DATA_W-1:0] dn_rsp_rdata,
    input logic [DATA_W-1:0] up_rsp_rdata,
    input logic              req_hit,
    input logic              rsp_hit
);

    AST_WR_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        req_hit |-> (dn_wdata == {req_wdata[HD-1:0], req_wdata[DATA_W-1:HD]}
                     && dn_wstrb == {req_wstrb[HS-1:0], req_wstrb[STRB_W-1:HS]})); // R8

    AST_RD_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> up_rsp_rdata == {dn_rsp_rdata[HD-1:0], dn_rsp_rdata[DATA_W-1:HD]}); // R9

    AST_WR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_hit |-> (dn_wdata == req_wdata && dn_wstrb == req_wstrb)); // R10

    AST_RD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> up_rsp_rdata == dn_rsp_rdata); // R10

    AST_HANDSHAKE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid == req_valid && req_ready == dn_ready && dn_addr == req_addr); // R10

    AST_SIZE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel == 2'd1 |-> cfg_rdata[ADDR_W-1:4] == '0); // R2

    AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel == 2'd0 |-> cfg_rdata[15:0] == '0); // R3

    AST_DIS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel == 2'd2 |-> cfg_rdata[ADDR_W-1:1] == '0); // R4

endmodule

bind endian_region_swapper region_swap_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_sel      (cfg_sel),
    .cfg_rdata    (cfg_rdata),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_wstrb    (req_wstrb),
    .dn_valid     (dn_valid),
    .dn_ready     (dn_ready),
    .dn_addr      (dn_addr),
    .dn_wdata     (dn_wdata),
    .dn_wstrb     (dn_wstrb),
    .dn_rsp_rdata (dn_rsp_rdata),
    .up_rsp_rdata (up_rsp_rdata),
    .req_hit      (req_hit),
    .rsp_hit      (rsp_hit)
);

// File: tb/test_endian_region_swapper.sv
// Self-checking bench: directed window-edge cases, then seeded random
// traffic checked against a bench-side window model.
module test_endian_region_swapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_region = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0, req_ready;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_wstrb = '0;
    logic        dn_valid, dn_ready = 1'b0;
    logic [31:0] dn_addr;
    logic [63:0] dn_wdata;
    logic [7:0]  dn_wstrb;
    logic        dn_rsp_valid = 1'b0, dn_rsp_ready;
    logic [31:0] dn_rsp_addr = '0;
    logic [63:0] dn_rsp_rdata = '0;
    logic        up_rsp_valid, up_rsp_ready = 1'b0;
    logic [63:0] up_rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] m_base [8];
    logic [3:0]  m_size [8];
    logic        m_dis  [8];

    always #2 clk = ~clk;  // 250 MHz

    endian_region_swapper i_endian_region_swapper (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] swap_w(input logic [63:0] d, input bit s);
        return s ? {d[31:0], d[63:32]} : d;
    endfunction

    function automatic logic [7:0] swap_s(input logic [7:0] d, input bit s);
        return s ? {d[3:0], d[7:4]} : d;
    endfunction

    // Bench model of the window decode.
    function automatic bit model_hit(input logic [31:0] a);
        bit h = 1'b0;
        for (int r = 0; r < 8; r++) begin
            if (!m_dis[r] && m_size[r] <= 4'd11) begin
                logic [63:0] span = 64'h1 << (16 + int'(m_size[r]));
                logic [63:0] lo   = {32'h0, m_base[r], 16'h0} & ~(span - 1);
                if ({32'h0, a} >= lo && {32'h0, a} < lo + span) h = 1'b1;
            end
        end
        return h;
    endfunction

    task automatic cfg_write(input int r, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_region = 3'(r); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            2'd0: m_base[r] = d[31:16];
            2'd1: m_size[r] = d[3:0];
            2'd2: m_dis[r]  = d[0];
            default: ;
        endcase
    endtask

    task automatic cfg_read(input int r, input logic [1:0] sel, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_region = 3'(r); cfg_sel = sel;
        #1 chk(req, {32'h0, cfg_rdata}, {32'h0, exp});
    endtask

    // Drive one write beat and one read beat; check data, strobes, handshakes.
    task automatic access(input logic [31:0] a, input logic [31:0] ra,
                          input bit wh, input bit rh, input string req);
        logic [63:0] wd = {$urandom, $urandom};
        logic [63:0] rd = {$urandom, $urandom};
        logic [7:0]  st = 8'($urandom);
        logic [3:0]  hs = 4'($urandom);
        @(negedge clk);
        req_addr = a; req_wdata = wd; req_wstrb = st;
        dn_rsp_addr = ra; dn_rsp_rdata = rd;
        req_valid = hs[0]; dn_ready = hs[1]; dn_rsp_valid = hs[2]; up_rsp_ready = hs[3];
        #1;
        chk({req, (wh ? " R8 wdata" : " R10 wdata")}, dn_wdata, swap_w(wd, wh));
        chk({req, (wh ? " R8 wstrb" : " R10 wstrb")}, {56'h0, dn_wstrb}, {56'h0, swap_s(st, wh)});
        chk({req, (rh ? " R9 rdata" : " R10 rdata")}, up_rsp_rdata, swap_w(rd, rh));
        chk("R10 handshake", {28'h0, dn_valid, req_ready, up_rsp_valid, dn_rsp_ready, dn_addr},
            {28'h0, hs[0], hs[1], hs[2], hs[3], a});
    endtask

    initial begin
        #(4 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        if (!done) begin
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 8; r++) begin
            m_base[r] = '0; m_dis[r] = 1'b0;
        end
        m_size[0] = 6; m_size[1] = 9; m_size[2] = 4; m_size[3] = 8;
        m_size[4] = 5; m_size[5] = 10; m_size[6] = 0; m_size[7] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        for (int r = 0; r < 8; r++) begin
            cfg_read(r, 2'd1, {28'h0, m_size[r]}, "R1 size");
            cfg_read(r, 2'd2, 32'h0, "R1 dis");
            cfg_read(r, 2'd0, 32'h0, "R1 base");
        end

        // R2, R3, R4: field widths
        cfg_write(4, 2'd1, 32'hFFFF_FFF3);
        cfg_read(4, 2'd1, 32'h0000_0003, "R2");
        cfg_write(4, 2'd0, 32'h1234_5678);
        cfg_read(4, 2'd0, 32'h1234_0000, "R3");
        cfg_write(4, 2'd2, 32'hFFFF_FFFF);
        cfg_read(4, 2'd2, 32'h0000_0001, "R4");

        // Disable every window, then build directed cases.
        for (int r = 0; r < 8; r++) cfg_write(r, 2'd2, 32'h1);

        // R5: 256 KB window at 0x0040_0000
        cfg_write(2, 2'd0, 32'h0040_0000);
        cfg_write(2, 2'd1, 32'h2);
        cfg_write(2, 2'd2, 32'h0);
        access(32'h0040_0000, 32'h0043_FFFF, 1'b1, 1'b1, "R5 edges in");
        access(32'h0044_0000, 32'h003F_FFFF, 1'b0, 1'b0, "R5 edges out");

        // R7: same window disabled
        cfg_write(2, 2'd2, 32'h1);
        access(32'h0041_0000, 32'h0041_0000, 1'b0, 1'b0, "R7 disabled");

        // R6: reserved code over the same base
        cfg_write(2, 2'd2, 32'h0);
        for (int c = 12; c < 16; c++) begin
            cfg_write(2, 2'd1, 32'(c));
            access(32'h0040_0000, 32'h0040_1000, 1'b0, 1'b0, "R6 reserved");
        end

        // R11: two overlapping windows swap once
        cfg_write(2, 2'd1, 32'h2);
        cfg_write(3, 2'd0, 32'h0040_0000);
        cfg_write(3, 2'd1, 32'h0);
        cfg_write(3, 2'd2, 32'h0);
        access(32'h0040_8000, 32'h0040_FFF8, 1'b1, 1'b1, "R11 overlap");

        // R5: largest legal window, 128 MB at 0x0800_0000
        cfg_write(7, 2'd0, 32'h0800_0000);
        cfg_write(7, 2'd1, 32'd11);
        cfg_write(7, 2'd2, 32'h0);
        access(32'h0FFF_FFFC, 32'h0800_0000, 1'b1, 1'b1, "R5 max in");
        access(32'h1000_0000, 32'h07FF_FFFC, 1'b0, 1'b0, "R5 max out");

        // Random traffic against the model (fixed seed).
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, ra;
            int r;
            if (i % 40 == 0) begin
                r = int'($urandom % 8);
                cfg_write(r, 2'd0, $urandom);
                cfg_write(r, 2'd1, $urandom % 16);
                cfg_write(r, 2'd2, 32'(($urandom % 4) == 0));
            end
            r = int'($urandom % 8);
            a  = {m_base[r], 16'h0} + ($urandom % (32'h2 << (16 + int'(m_size[r] > 11 ? 4'd0 : m_size[r])))) - 32'h8000;
            ra = ($urandom % 2 == 0) ? a : $urandom;
            access(a, ra, model_hit(a), model_hit(ra), "R5 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule